// File: doc/BRIEF.md
# Signed/Unsigned Decimal Digit Selector

This block turns a 4-bit binary value into the digits a two-digit decimal readout needs. A single mode bit says how the value is read. When the value is read as unsigned (0 to 15), the block produces a tens flag and a units digit. When the value is read as two's complement (-8 to +7), it produces a minus flag and the units digit of the magnitude.

The block is purely combinational. One shared units output is driven either by a binary-to-BCD split or by a two's-complement magnitude path. A small control unit decodes the mode bit into a struct of select strobes, and the datapath acts on those strobes. Segment encoding and the arithmetic that produces the value sit outside this block.

Top module: `dec_disp_sel`

## Requirements
- R1: `modeSigned` = 0 selects the unsigned reading and `modeSigned` = 1 selects the two's-complement reading of `valueIn`. Bit 3 of `valueIn` is the sign bit in the signed reading.
- R2: In unsigned mode, an input from 0 to 9 gives `unitsDigit` equal to the input and `tensFlag` = 0.
- R3: In unsigned mode, an input from 10 to 15 gives `unitsDigit` equal to the input minus 10 and `tensFlag` = 1. `unitsDigit` never exceeds 9 in either mode.
- R4: In unsigned mode, `minusFlag` is 0 for every input.
- R5: In signed mode, `minusFlag` equals bit 3 of `valueIn`.
- R6: In signed mode, `unitsDigit` is the two's-complement magnitude of the input. Input 4'b1000 gives 8 with `minusFlag` = 1.
- R7: In signed mode, `tensFlag` is 0 for every input.
- R8: The outputs follow any change of `valueIn` or `modeSigned` in the same time step, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valueIn | input | 4 | Binary value to be shown |
| modeSigned | input | 1 | 0 = unsigned reading, 1 = two's-complement reading |
| unitsDigit | output | 4 | Decimal units digit (0 to 9) |
| tensFlag | output | 1 | Tens digit is 1 (unsigned mode only) |
| minusFlag | output | 1 | Value is negative (signed mode only) |

## Verification
The block has no state, so a wrong internal select shows up on the ports in the same time step as the stimulus. If the mode strobes are decoded wrongly, the wrong path drives the units digit, or a tens or minus flag appears in the mode where it must stay low. The bench applies all 32 combinations of mode and input, and it also switches the mode with the value held fixed. A stuck strobe or a wrong BCD threshold therefore shows up as a digit or flag mismatch at a known input.

// File: rtl/dec_disp_pkg.sv
package dec_disp_pkg;
  localparam int VAL_W   = 4;
  localparam int DIGIT_W = 4;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } dispMode_e;

  typedef struct packed {
    logic selMagnitude;
    logic enTens;
    logic enMinus;
  } dispStrobe_t;
endpackage

// File: rtl/dec_disp_ctrl.sv
module dec_disp_ctrl
  import dec_disp_pkg::*;
(
  input  logic        modeSigned,
  output dispStrobe_t strobes
);
  dispMode_e mode;

  always_comb begin
    mode = dispMode_e'(modeSigned);
    strobes = '0;
    unique case (mode)
      MODE_UNSIGNED: strobes.enTens = 1'b1;
      MODE_SIGNED: begin
        strobes.selMagnitude = 1'b1;
        strobes.enMinus      = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  // R1: exactly one of the tens or minus paths is enabled
  always_comb begin
    if (!$isunknown(modeSigned)) begin
      assert_one_flag_path_R1: assert ($countones({strobes.enTens, strobes.enMinus}) == 1)
        else $error("R1 strobe decode not exclusive");
    end
  end
endmodule

// File: rtl/dec_disp_dp.sv
module dec_disp_dp
  import dec_disp_pkg::*;
#(
  parameter int W  = VAL_W,
  parameter int DW = DIGIT_W
) (
  input  logic [W-1:0]  valueIn,
  input  dispStrobe_t   strobes,
  output logic [DW-1:0] unitsDigit,
  output logic          tensFlag,
  output logic          minusFlag
);
  localparam logic [W-1:0] TEN = W'(10);

  logic          signBit;
  logic          geTen;
  logic [W-1:0]  bcdUnits;
  logic [W-1:0]  magnitude;

  // binary-to-BCD split for 0..15
  always_comb begin
    geTen    = (valueIn >= TEN);
    bcdUnits = geTen ? (valueIn - TEN) : valueIn;
  end

  // two's-complement magnitude
  always_comb begin
    signBit   = valueIn[W-1];
    magnitude = signBit ? (~valueIn + W'(1)) : valueIn;
  end

  always_comb begin
    unitsDigit = DW'(strobes.selMagnitude ? magnitude : bcdUnits);
    tensFlag   = strobes.enTens  & geTen;
    minusFlag  = strobes.enMinus & signBit;
  end

  always_comb begin
    if (!$isunknown({valueIn, strobes})) begin
      assert_units_decimal_R3: assert (unitsDigit <= DW'(9))
        else $error("R3 units digit above 9");
      assert_minus_only_signed_R4: assert (!(minusFlag && !strobes.enMinus))
        else $error("R4 minus set outside signed mode");
      assert_minus_sign_R5: assert (!strobes.enMinus || (minusFlag == valueIn[W-1]))
        else $error("R5 minus does not match sign");
      assert_tens_only_unsigned_R7: assert (!(tensFlag && strobes.selMagnitude))
        else $error("R7 tens set in signed mode");
    end
  end
endmodule

// File: rtl/dec_disp_sel.sv
module dec_disp_sel
  import dec_disp_pkg::*;
(
  input  logic [3:0] valueIn,
  input  logic       modeSigned,
  output logic [3:0] unitsDigit,
  output logic       tensFlag,
  output logic       minusFlag
);
  dispStrobe_t strobes;

  dec_disp_ctrl u_ctrl (
    .modeSigned (modeSigned),
    .strobes    (strobes)
  );

  dec_disp_dp #(.W(VAL_W), .DW(DIGIT_W)) u_dp (
    .valueIn    (valueIn),
    .strobes    (strobes),
    .unitsDigit (unitsDigit),
    .tensFlag   (tensFlag),
    .minusFlag  (minusFlag)
  );
endmodule

// File: tb/tb_dec_disp_sel.sv
module tb_dec_disp_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] valueIn = '0;
  logic modeSigned = 1'b0;
  logic [3:0] unitsDigit;
  logic tensFlag, minusFlag;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dec_disp_sel dut (
    .valueIn    (valueIn),
    .modeSigned (modeSigned),
    .unitsDigit (unitsDigit),
    .tensFlag   (tensFlag),
    .minusFlag  (minusFlag)
  );

  task automatic check(input string req, input logic [3:0] v, input logic m);
    int sv;
    logic [3:0] eU;
    logic eT, eM;
    @(posedge clk);
    valueIn = v;
    modeSigned = m;
    @(negedge clk);
    if (!m) begin
      eT = (v > 4'd9);
      eU = eT ? 4'(int'(v) - 10) : v;
      eM = 1'b0;
    end else begin
      sv = (int'(v) >= 8) ? int'(v) - 16 : int'(v);
      eM = (sv < 0);
      eU = 4'(sv < 0 ? -sv : sv);
      eT = 1'b0;
    end
    compared++;
    if ({unitsDigit, tensFlag, minusFlag} !== {eU, eT, eM}) begin
      mismatched++;
      $display("FAIL %s mode=%0d in=%0d: got units=%0d tens=%0b minus=%0b, expected units=%0d tens=%0b minus=%0b",
               req, m, v, unitsDigit, tensFlag, minusFlag, eU, eT, eM);
    end
  endtask

  task automatic t_reset_state;   // R2 with input 0 after reset
    check("R2 reset", 4'd0, 1'b0);
  endtask

  task automatic t_unsigned_low;  // R2, R4
    for (int i = 0; i < 10; i++) check("R2/R4", 4'(i), 1'b0);
  endtask

  task automatic t_unsigned_high; // R3, R4
    for (int i = 10; i < 16; i++) check("R3/R4", 4'(i), 1'b0);
  endtask

  task automatic t_signed_pos;    // R5, R6, R7
    for (int i = 0; i < 8; i++) check("R5/R6/R7", 4'(i), 1'b1);
  endtask

  task automatic t_signed_neg;    // R5, R6, R7, includes 4'b1000
    for (int i = 8; i < 16; i++) check("R5/R6/R7", 4'(i), 1'b1);
    check("R6 most negative", 4'b1000, 1'b1);
  endtask

  task automatic t_mode_switch;   // R1, R8: same value, mode toggled
    check("R1/R8", 4'd13, 1'b0);
    check("R1/R8", 4'd13, 1'b1);
    check("R1/R8", 4'd9, 1'b1);
    check("R1/R8", 4'd9, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_unsigned_low();
    t_unsigned_high();
    t_signed_pos();
    t_signed_neg();
    t_mode_switch();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          compared++;
          mismatched++;
          $display("FAIL watchdog: got timeout, expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule